// File: doc/BRIEF.md
# Receive Status Queue with Two-Stage Peek

This block keeps one small status word per received character of a serial channel, in arrival order, so that the error flags of every character stay paired with its data until software consumes it. The receiver pushes a status word each time it stores a character. The reader pops one entry each time it takes a character out of the data queue.

Three registered, read-only views let a processor inspect the front of the queue without disturbing it. The head view shows the oldest entry and the follow view shows the one behind it, each with a presence bit. The combined view ORs the flags of both. With the head and follow views, software can tell which character carries the error that raised an interrupt, and whether two characters are present so that both can be taken in a single word access. Reading the views has no side effect and never raises an interrupt. Three clear sources (a receive-side clear, a whole-channel clear and a stop condition) each empty the queue.

Top module: `rx_status_queue`

## Requirements
- R1: The queue holds DEPTH (default 32, must be a power of two) entries and returns them in the order they were pushed; exactly DEPTH pushes into an empty queue are all kept.
- R2: `head_view` bit 0 is 1 when the queue holds at least one entry; bits [FLAG_W:1] then carry the oldest entry's flags (flag i at bit i+1). When the queue is empty the whole view reads 0.
- R3: `follow_view` uses the same layout for the second-oldest entry; bit 0 is 1 only when at least two entries are held, and the view reads 0 otherwise.
- R4: `combined_view` bits [FLAG_W:1] are the bitwise OR of the flag fields of `head_view` and `follow_view`, and bit 0 is the OR of their presence bits.
- R5: All views and `overflow` are registers; a push, pop or clear sampled at a rising clock edge is visible on them right after that same edge.
- R6: A pop removes the oldest entry, so the old second entry becomes the head and the third, if any, becomes the second. A pop on an empty queue has no effect.
- R7: A push while DEPTH entries are held and no pop is accepted is dropped (contents unchanged) and sets `overflow`, which stays 1 until reset or a clear.
- R8: A push and a pop in the same cycle leave the occupancy unchanged and keep the order; this also holds when the queue is full, where neither is dropped and `overflow` is not set.
- R9: While any of `rx_clear`, `chan_clear` or `stop_mode` is 1 at an edge, the queue is emptied, `overflow` is cleared, all views read 0 after that edge, and pushes and pops in that cycle are ignored.
- R10: With `framed_mode` = 0 only flags 0 to ASYNC_FLAGS-1 (default 0..3) are shown and higher flag bits of every view read 0; with `framed_mode` = 1 all FLAG_W (default 5) flags are shown. Stored flags are not changed by the mode.
- R11: A synchronous active-high `rst` empties the queue, clears `overflow` and sets all views to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Store `push_flags` as a new entry |
| push_flags | input | FLAG_W | Error flags of the received character |
| pop | input | 1 | Remove the oldest entry |
| rx_clear | input | 1 | Receive-side clear |
| chan_clear | input | 1 | Whole-channel clear |
| stop_mode | input | 1 | Stop condition, holds the queue empty |
| framed_mode | input | 1 | 0: character mode flag set, 1: frame mode flag set |
| head_view | output | FLAG_W+1 | Oldest entry: presence at bit 0, flags above |
| follow_view | output | FLAG_W+1 | Second-oldest entry: presence at bit 0, flags above |
| combined_view | output | FLAG_W+1 | OR of head and follow presence and flags |
| overflow | output | 1 | Sticky dropped-push indication |

## Verification
The assertions take for granted that `rst` is high for at least one edge before any other input matters and that every input is a known 0 or 1 at each edge; pops on an empty queue, pushes into a full one and clears at any time are legal and covered by the properties. The stimulus asserts reset first, then changes inputs only at falling edges, fills the queue past its limit, mixes push and pop at full and empty, pulses each clear source with a push beside it, toggles the flag-set mode, and ends with a long pseudo-random run compared against a queue model every cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic {
    FMT_CHAR  = 1'b0,
    FMT_FRAME = 1'b1
  } fmt_e;

  // Low-order ones mask of n bits, saturating at 32 bits.
  function automatic logic [31:0] low_ones(input int unsigned n);
    if (n >= 32) return '1;
    return (32'd1 << n) - 32'd1;
  endfunction

endpackage

// File: rtl/rsq_store.sv
module rsq_store #(
  parameter int DEPTH  = 32,
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [FLAG_W-1:0] push_flags,
  input  logic              pop,
  input  logic              flush,
  output logic              nxt_head_valid,
  output logic [FLAG_W-1:0] nxt_head_flags,
  output logic              nxt_follow_valid,
  output logic [FLAG_W-1:0] nxt_follow_flags,
  output logic              overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [FLAG_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_ptr, wr_ptr, rd_nxt, rd_nxt2;
  logic [CW-1:0]     count, count_nxt;
  logic              pop_ok, push_ok, drop;

  initial begin
    if ((1 << AW) != DEPTH) $error("rsq_store: DEPTH must be a power of two");
  end

  always_comb begin
    pop_ok    = pop && (count != '0) && !flush;
    push_ok   = push && !flush && ((count != FULL_CNT) || pop_ok);
    drop      = push && !flush && !push_ok;
    rd_nxt    = rd_ptr + AW'(pop_ok);
    rd_nxt2   = rd_nxt + AW'(1);
    count_nxt = flush ? '0 : (count + CW'(push_ok) - CW'(pop_ok));
  end

  // Storage: write-only port with no reset so a RAM can be inferred.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_flags;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      rd_ptr <= rd_nxt;
      count  <= count_nxt;
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (drop) overflow <= 1'b1;
    end
  end

  // Look-ahead of the two front entries, with bypass of the word being written.
  always_comb begin
    nxt_head_valid   = !rst && (count_nxt != '0);
    nxt_follow_valid = !rst && (count_nxt > CW'(1));
    if (push_ok && (wr_ptr == rd_nxt)) nxt_head_flags = push_flags;
    else                               nxt_head_flags = mem[rd_nxt];
    if (push_ok && (wr_ptr == rd_nxt2)) nxt_follow_flags = push_flags;
    else                                nxt_follow_flags = mem[rd_nxt2];
    if (!nxt_head_valid)   nxt_head_flags   = '0;
    if (!nxt_follow_valid) nxt_follow_flags = '0;
  end

  // R1: occupancy never exceeds capacity
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R7: a dropped push leaves the occupancy as it was
  a_r7_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
    drop |=> $stable(count));

  // R7: the overflow indication is sticky until a clear
  a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
    (overflow && !flush) |=> overflow);

  // R8: simultaneous accepted push and pop keep the occupancy
  a_r8_pair_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> $stable(count));

  // R9: any clear source empties the queue
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0) && !overflow);

endmodule

// File: rtl/rsq_view.sv
module rsq_view #(
  parameter int FLAG_W      = 5,
  parameter int ASYNC_FLAGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              framed_mode,
  input  logic              head_valid,
  input  logic [FLAG_W-1:0] head_flags,
  input  logic              follow_valid,
  input  logic [FLAG_W-1:0] follow_flags,
  output logic [FLAG_W:0]   head_view,
  output logic [FLAG_W:0]   follow_view,
  output logic [FLAG_W:0]   combined_view
);
  import rsq_pkg::*;

  localparam logic [31:0]       CHAR_MASK32 = low_ones(ASYNC_FLAGS);
  localparam logic [FLAG_W-1:0] CHAR_MASK   = CHAR_MASK32[FLAG_W-1:0];

  fmt_e              fmt;
  logic [FLAG_W-1:0] mask, hf, ff;

  always_comb begin
    fmt  = fmt_e'(framed_mode);
    mask = (fmt == FMT_FRAME) ? {FLAG_W{1'b1}} : CHAR_MASK;
    hf   = head_flags & mask;
    ff   = follow_flags & mask;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_view     <= '0;
      follow_view   <= '0;
      combined_view <= '0;
    end else begin
      head_view     <= {hf, head_valid};
      follow_view   <= {ff, follow_valid};
      combined_view <= {hf | ff, head_valid | follow_valid};
    end
  end

  // R3: a second entry can only be present behind a head entry
  a_r3_follow_needs_head: assert property (@(posedge clk) disable iff (rst)
    follow_view[0] |-> head_view[0]);

  // R2: an empty head stage shows no stale flags
  a_r2_empty_head_zero: assert property (@(posedge clk) disable iff (rst)
    !head_view[0] |-> (head_view == '0) && (follow_view == '0));

  // R4: the combined presence bit follows the head presence bit
  a_r4_combined_presence: assert property (@(posedge clk) disable iff (rst)
    combined_view[0] == head_view[0]);

  // R9: clears zero every view on the next edge
  a_r9_clear_views: assert property (@(posedge clk) disable iff (rst)
    flush |=> (head_view == '0) && (follow_view == '0) && (combined_view == '0));

endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue #(
  parameter int DEPTH       = 32,
  parameter int FLAG_W      = 5,
  parameter int ASYNC_FLAGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [FLAG_W-1:0] push_flags,
  input  logic              pop,
  input  logic              rx_clear,
  input  logic              chan_clear,
  input  logic              stop_mode,
  input  logic              framed_mode,
  output logic [FLAG_W:0]   head_view,
  output logic [FLAG_W:0]   follow_view,
  output logic [FLAG_W:0]   combined_view,
  output logic              overflow
);
  logic              flush;
  logic              n_head_v, n_follow_v;
  logic [FLAG_W-1:0] n_head_f, n_follow_f;

  assign flush = rx_clear | chan_clear | stop_mode;

  rsq_store #(.DEPTH(DEPTH), .FLAG_W(FLAG_W)) i_store (
    .clk              (clk),
    .rst              (rst),
    .push             (push),
    .push_flags       (push_flags),
    .pop              (pop),
    .flush            (flush),
    .nxt_head_valid   (n_head_v),
    .nxt_head_flags   (n_head_f),
    .nxt_follow_valid (n_follow_v),
    .nxt_follow_flags (n_follow_f),
    .overflow         (overflow)
  );

  rsq_view #(.FLAG_W(FLAG_W), .ASYNC_FLAGS(ASYNC_FLAGS)) i_view (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .framed_mode   (framed_mode),
    .head_valid    (n_head_v),
    .head_flags    (n_head_f),
    .follow_valid  (n_follow_v),
    .follow_flags  (n_follow_f),
    .head_view     (head_view),
    .follow_view   (follow_view),
    .combined_view (combined_view)
  );

endmodule

// File: tb/test_rx_status_queue.sv
module test_rx_status_queue;
  localparam int DEPTH = 32;
  localparam int FW    = 5;

  logic          clk = 1'b0;
  logic          rst, push, pop, rx_clear, chan_clear, stop_mode, framed_mode;
  logic [FW-1:0] push_flags;
  logic [FW:0]   head_view, follow_view, combined_view;
  logic          overflow;

  always #4 clk = ~clk;

  rx_status_queue #(.DEPTH(DEPTH), .FLAG_W(FW), .ASYNC_FLAGS(4)) i_rx_status_queue (
    .clk(clk), .rst(rst), .push(push), .push_flags(push_flags), .pop(pop),
    .rx_clear(rx_clear), .chan_clear(chan_clear), .stop_mode(stop_mode),
    .framed_mode(framed_mode), .head_view(head_view), .follow_view(follow_view),
    .combined_view(combined_view), .overflow(overflow)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [FW-1:0] q[$];
  logic          m_ovf;

  function automatic logic [FW-1:0] cur_mask();
    return framed_mode ? 5'h1F : 5'h0F;
  endfunction

  function automatic logic [FW:0] exp_stage(int idx);
    if (q.size() > idx) return {q[idx] & cur_mask(), 1'b1};
    return '0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [FW:0] act, input logic [FW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [FW:0] h, f;
    h = exp_stage(0);
    f = exp_stage(1);
    chk(tag, "head_view", head_view, h);
    chk(tag, "follow_view", follow_view, f);
    chk(tag, "combined_view", combined_view, h | f);
    chk(tag, "overflow", {{FW{1'b0}}, overflow}, {{FW{1'b0}}, m_ovf});
  endtask

  // Called at a falling edge; applies one cycle and compares at the next falling edge.
  task automatic step(input logic pu, input logic [FW-1:0] fl, input logic po,
                      input logic rc, input logic cc, input logic sm, input string tag);
    bit popok, pushok;
    push = pu; push_flags = fl; pop = po;
    rx_clear = rc; chan_clear = cc; stop_mode = sm;
    @(posedge clk);
    if (rc || cc || sm) begin
      q.delete();
      m_ovf = 1'b0;
    end else begin
      popok  = po && (q.size() > 0);
      pushok = pu && ((q.size() < DEPTH) || popok);
      if (pu && !pushok) m_ovf = 1'b1;
      if (popok) void'(q.pop_front());
      if (pushok) q.push_back(fl);
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    push = 1'b1; pop = 1'b0; push_flags = 5'h1F;
    rx_clear = 1'b0; chan_clear = 1'b0; stop_mode = 1'b0;
    repeat (2) @(posedge clk);
    q.delete();
    m_ovf = 1'b0;
    @(negedge clk);
    compare(tag);
    rst = 1'b0; push = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    framed_mode = 1'b1;
    @(negedge clk);
    // R11: reset state, even with push requested during reset
    do_reset("R11");

    // R2 R3 R4 R5: distinct flag patterns, visible right after the edge
    step(1, 5'h01, 0, 0, 0, 0, "R2");
    step(1, 5'h12, 0, 0, 0, 0, "R3");
    step(1, 5'h0C, 0, 0, 0, 0, "R4");
    step(1, 5'h00, 0, 0, 0, 0, "R5");

    // R6: pops advance the front entries; empty pops ignored
    step(0, 5'h00, 1, 0, 0, 0, "R6");
    step(0, 5'h00, 1, 0, 0, 0, "R6");
    step(0, 5'h00, 1, 0, 0, 0, "R6");
    step(0, 5'h00, 1, 0, 0, 0, "R6");
    step(0, 5'h00, 1, 0, 0, 0, "R6");
    // R8: push and pop on empty queue stores the word
    step(1, 5'h15, 1, 0, 0, 0, "R8");
    step(0, 5'h00, 1, 0, 0, 0, "R6");

    // R1: fill to capacity, R7: extra push dropped, overflow sticky
    for (int i = 0; i < DEPTH; i++) step(1, FW'(i), 0, 0, 0, 0, "R1");
    step(1, 5'h1F, 0, 0, 0, 0, "R7");
    step(0, 5'h00, 0, 0, 0, 0, "R7");
    // R8: push and pop while full
    step(1, 5'h1E, 1, 0, 0, 0, "R8");
    step(1, 5'h1D, 1, 0, 0, 0, "R8");
    // R10: character mode hides flag 4 without changing stored flags
    framed_mode = 1'b0;
    step(0, 5'h00, 0, 0, 0, 0, "R10");
    for (int i = 0; i < DEPTH; i++) step(0, 5'h00, 1, 0, 0, 0, "R1");
    step(1, 5'h1F, 0, 0, 0, 0, "R10");
    framed_mode = 1'b1;
    step(0, 5'h00, 0, 0, 0, 0, "R10");

    // R9: each clear source empties and ignores a push in the same cycle
    step(1, 5'h03, 0, 0, 0, 0, "R9");
    step(1, 5'h07, 0, 1, 0, 0, "R9");
    step(1, 5'h11, 0, 0, 0, 0, "R9");
    step(1, 5'h11, 0, 0, 1, 0, "R9");
    step(1, 5'h09, 0, 0, 0, 0, "R9");
    step(1, 5'h09, 1, 0, 0, 1, "R9");
    step(1, 5'h09, 0, 0, 0, 1, "R9");
    step(1, 5'h0A, 0, 0, 0, 0, "R9");

    // R11: reset in the middle of traffic
    step(1, 5'h1B, 0, 0, 0, 0, "R11");
    do_reset("R11");

    // R5 R6 R7 R8: pseudo-random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if ((i % 500) == 250) framed_mode = ~framed_mode;
      step((r % 3) != 0, FW'($urandom), (r % 4) == 1,
           r == 97, r == 98, r == 99, "R5");
    end

    finish_run();
  end
endmodule